// File: doc/BRIEF.md
# SuperSpeed PHY Power Sequencer

This block drives the control word of a high-speed serial PHY through its bring-up and shut-down orderings. A single-cycle start request begins bring-up. The PHY reset bit is pulsed for a programmed number of cycles. The reference-pad select is then chosen from a flag that tells whether an external oscillator is fitted. After a settle interval, PHY enable and lane-0 power present switch on in the same update, and a ready flag is raised.

A single-cycle stop request runs shut-down in three one-cycle steps. Enable and lane power drop first, then the pad select clears, and last the test power-down bit is set so the PHY enters retention. Both delays are parameters counted in clock cycles. A request that arrives while a sequence is running is remembered and carried out as soon as that sequence ends.

Top module: `phy_pwr_seq`

## Requirements
- R1: A synchronous reset clears every bit of `ctrlWord` and drops `ready`; the block waits in the powered-down idle state.
- R2: A start seen in idle sets the PHY reset bit (bit 7) and clears test power-down (bit 27) at the next clock edge. Bit 7 then stays high for exactly `RST_CYCLES` cycles.
- R3: One clock edge after bit 7 falls, the reference-pad select bit (bit 28) takes the value of `oscPresent` sampled in that cycle.
- R4: Exactly `SETTLE_CYCLES` cycles after the pad-select update, PHY enable (bit 8) and lane-0 power present (bit 24) rise at the same edge. Nothing else in the word changes during the wait.
- R5: `ready` is high only while the PHY is fully powered up. It rises at the same edge as bit 8.
- R6: A stop seen while powered up clears bits 8 and 24 and drops `ready` at the next edge. Bit 28 clears one edge later, and bit 27 sets one edge after that.
- R7: A stop that arrives during bring-up is held and starts shut-down at the first edge after bring-up completes. A start that arrives during shut-down is held and starts bring-up at the first edge after shut-down completes.
- R8: A start while powered up or powering up, and a stop while idle or powering down, are dropped and leave `ctrlWord` and `ready` unchanged.
- R9: Only bits 7, 8, 24, 27 and 28 of `ctrlWord` are ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | One-cycle bring-up request |
| stopReq | input | 1 | One-cycle shut-down request |
| oscPresent | input | 1 | External reference oscillator is fitted |
| ctrlWord | output | 32 | PHY control word image |
| ready | output | 1 | PHY fully powered up |

## Verification
The hardest situations to reach from the ports are the held requests. A stop must land inside the reset or settle window. A start must land inside the three-cycle shut-down. The stimulus issues a stop ten cycles into bring-up, and a start one cycle after a stop, so each request sits in the pending flag before it is acted on. A scoreboard predicts, from the request time and the two delay parameters, the exact cycle of every change in the word. This exposes any slip of one cycle in the held-request handover.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

  localparam int CTRL_W   = 32;
  localparam int BIT_RST  = 7;
  localparam int BIT_EN   = 8;
  localparam int BIT_LANE = 24;
  localparam int BIT_TPD  = 27;
  localparam int BIT_PAD  = 28;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RST,
    ST_PAD,
    ST_SETTLE,
    ST_ON,
    ST_DN_PAD,
    ST_DN_RET
  } seqState_t;

  typedef struct packed {
    logic assertRst;
    logic releaseRst;
    logic latchPad;
    logic raiseEn;
    logic dropEn;
    logic dropPad;
    logic enterRet;
    logic loadRst;
    logic loadSettle;
  } seqStrobe_t;

endpackage

// File: rtl/phy_pwr_seq_ctrl.sv
module phy_pwr_seq_ctrl
  import phy_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       cntDone,
  output seqStrobe_t strobe,
  output logic       ready
);

  seqState_t state, nxtState;
  logic      startPend, stopPend;
  logic      upPhase, downPhase, goUp, goDown;

  assign upPhase   = (state == ST_RST) || (state == ST_PAD) || (state == ST_SETTLE);
  assign downPhase = (state == ST_DN_PAD) || (state == ST_DN_RET);
  assign goUp      = (state == ST_OFF) && (startReq || startPend);
  assign goDown    = (state == ST_ON) && (stopReq || stopPend);
  assign ready     = (state == ST_ON);

  always_comb begin
    strobe   = '0;
    nxtState = state;
    case (state)
      ST_OFF: begin
        if (goUp) begin
          strobe.assertRst = 1'b1;
          strobe.loadRst   = 1'b1;
          nxtState         = ST_RST;
        end
      end
      ST_RST: begin
        if (cntDone) begin
          strobe.releaseRst = 1'b1;
          nxtState          = ST_PAD;
        end
      end
      ST_PAD: begin
        strobe.latchPad   = 1'b1;
        strobe.loadSettle = 1'b1;
        nxtState          = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cntDone) begin
          strobe.raiseEn = 1'b1;
          nxtState       = ST_ON;
        end
      end
      ST_ON: begin
        if (goDown) begin
          strobe.dropEn = 1'b1;
          nxtState      = ST_DN_PAD;
        end
      end
      ST_DN_PAD: begin
        strobe.dropPad = 1'b1;
        nxtState       = ST_DN_RET;
      end
      ST_DN_RET: begin
        strobe.enterRet = 1'b1;
        nxtState        = ST_OFF;
      end
      default: nxtState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      startPend <= 1'b0;
      stopPend  <= 1'b0;
    end else begin
      state     <= nxtState;
      startPend <= goUp ? 1'b0 : (startPend | (startReq & downPhase));
      stopPend  <= goDown ? 1'b0 : (stopPend | (stopReq & upPhase));
    end
  end

endmodule

// File: rtl/phy_pwr_seq_dp.sv
module phy_pwr_seq_dp
  import phy_pwr_seq_pkg::*;
#(
  parameter int RST_CYCLES    = 100000,
  parameter int SETTLE_CYCLES = 1500000
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              oscPresent,
  output logic              cntDone,
  output logic [CTRL_W-1:0] ctrlWord
);

  localparam int MAX_CYC = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] delayCnt;
  logic rstBit, padBit, enBit, laneBit, tpdBit;

  assign cntDone = (delayCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      delayCnt <= '0;
    end else if (strobe.loadRst) begin
      delayCnt <= RST_LOAD;
    end else if (strobe.loadSettle) begin
      delayCnt <= SETTLE_LOAD;
    end else if (!cntDone) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstBit  <= 1'b0;
      padBit  <= 1'b0;
      enBit   <= 1'b0;
      laneBit <= 1'b0;
      tpdBit  <= 1'b0;
    end else begin
      if (strobe.assertRst) begin
        rstBit <= 1'b1;
        tpdBit <= 1'b0;
      end
      if (strobe.releaseRst) rstBit <= 1'b0;
      if (strobe.latchPad)   padBit <= oscPresent;
      if (strobe.raiseEn) begin
        enBit   <= 1'b1;
        laneBit <= 1'b1;
      end
      if (strobe.dropEn) begin
        enBit   <= 1'b0;
        laneBit <= 1'b0;
      end
      if (strobe.dropPad)  padBit <= 1'b0;
      if (strobe.enterRet) tpdBit <= 1'b1;
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_RST]  = rstBit;
    ctrlWord[BIT_EN]   = enBit;
    ctrlWord[BIT_LANE] = laneBit;
    ctrlWord[BIT_TPD]  = tpdBit;
    ctrlWord[BIT_PAD]  = padBit;
  end

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int RST_CYCLES    = 100000,
  parameter int SETTLE_CYCLES = 1500000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        oscPresent,
  output logic [31:0] ctrlWord,
  output logic        ready
);

  seqStrobe_t strobe;
  logic       cntDone;

  phy_pwr_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .stopReq  (stopReq),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .ready    (ready)
  );

  phy_pwr_seq_dp #(
    .RST_CYCLES    (RST_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .oscPresent (oscPresent),
    .cntDone    (cntDone),
    .ctrlWord   (ctrlWord)
  );

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk
  import phy_pwr_seq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] ctrlWord,
  input logic        ready
);

  localparam logic [31:0] USED_MASK =
    (32'd1 << BIT_RST) | (32'd1 << BIT_EN) | (32'd1 << BIT_LANE) |
    (32'd1 << BIT_TPD) | (32'd1 << BIT_PAD);

  logic rstBit, enBit, laneBit, tpdBit, padBit;
  assign rstBit  = ctrlWord[BIT_RST];
  assign enBit   = ctrlWord[BIT_EN];
  assign laneBit = ctrlWord[BIT_LANE];
  assign tpdBit  = ctrlWord[BIT_TPD];
  assign padBit  = ctrlWord[BIT_PAD];

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ctrlWord == 32'd0 && !ready));

  p_reset_excludes_enable_r2: assert property (@(posedge clk) disable iff (rst)
    rstBit |-> !enBit);

  p_enable_with_lane_r4: assert property (@(posedge clk) disable iff (rst)
    enBit == laneBit);

  p_ready_needs_power_r5: assert property (@(posedge clk) disable iff (rst)
    ready |-> (enBit && laneBit && !rstBit && !tpdBit));

  p_shutdown_order_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(enBit) |=> (!padBit && !tpdBit) ##1 tpdBit);

  p_used_bits_only_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrlWord & ~USED_MASK) == 32'd0);

endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrlWord (ctrlWord),
  .ready    (ready)
);

// File: tb/phy_pwr_seq_tb.sv
module phy_pwr_seq_tb;

  localparam int RC = 20;
  localparam int SC = 60;
  localparam int B_RST = 7, B_EN = 8, B_LANE = 24, B_TPD = 27, B_PAD = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic stopReq = 1'b0;
  logic oscPresent = 1'b0;
  logic [31:0] ctrlWord;
  logic ready;

  always #10 clk = ~clk;

  phy_pwr_seq #(.RST_CYCLES(RC), .SETTLE_CYCLES(SC)) u_dut (
    .clk(clk), .rst(rst), .startReq(startReq), .stopReq(stopReq),
    .oscPresent(oscPresent), .ctrlWord(ctrlWord), .ready(ready)
  );

  typedef struct {
    int          cyc;
    logic [31:0] word;
    logic        rdy;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int cycCnt = 0;
  int checks = 0;
  int errs = 0;
  logic [31:0] mWord = '0;
  logic        mRdy = 1'b0;
  int          busyUntil = 0;
  bit          mTargetOn = 1'b0;
  logic [31:0] lastWord;
  logic        lastRdy;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic pushExp(int cyc, logic [31:0] w, logic r, string tag);
    expItem_t it;
    if (w !== mWord || r !== mRdy) begin
      it.cyc = cyc; it.word = w; it.rdy = r; it.tag = tag;
      expQ.push_back(it);
    end
    mWord = w;
    mRdy  = r;
  endtask

  task automatic modelUp(int o, bit osc, bit pend);
    logic [31:0] w;
    w = mWord;
    w[B_TPD] = 1'b0; w[B_RST] = 1'b1;
    pushExp(o + 1, w, 1'b0, pend ? "R7" : "R2");
    w[B_RST] = 1'b0;
    pushExp(o + 1 + RC, w, 1'b0, "R2");
    w[B_PAD] = osc;
    pushExp(o + 2 + RC, w, 1'b0, "R3");
    w[B_EN] = 1'b1; w[B_LANE] = 1'b1;
    pushExp(o + 2 + RC + SC, w, 1'b1, "R4");
    busyUntil = o + 2 + RC + SC;
  endtask

  task automatic modelDown(int o, bit pend);
    logic [31:0] w;
    w = mWord;
    w[B_EN] = 1'b0; w[B_LANE] = 1'b0;
    pushExp(o + 1, w, 1'b0, pend ? "R7" : "R6");
    w[B_PAD] = 1'b0;
    pushExp(o + 2, w, 1'b0, "R6");
    w[B_TPD] = 1'b1;
    pushExp(o + 3, w, 1'b0, "R6");
    busyUntil = o + 3;
  endtask

  task automatic reqStart(bit osc);
    int c;
    @(negedge clk);
    oscPresent = osc;
    startReq = 1'b1;
    c = cycCnt;
    if (!mTargetOn) begin
      modelUp((c >= busyUntil) ? c : busyUntil, osc, c < busyUntil);
      mTargetOn = 1'b1;
    end
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic reqStop();
    int c;
    @(negedge clk);
    stopReq = 1'b1;
    c = cycCnt;
    if (mTargetOn) begin
      modelDown((c >= busyUntil) ? c : busyUntil, c < busyUntil);
      mTargetOn = 1'b0;
    end
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic waitIdle();
    while (cycCnt < busyUntil + 3) @(negedge clk);
  endtask

  // Monitor: every change at the outputs is matched against the next expected item.
  always @(negedge clk) begin
    if (rst) begin
      lastWord = ctrlWord;
      lastRdy  = ready;
    end else if (ctrlWord !== lastWord || ready !== lastRdy) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", $sformatf("unexpected change at cycle %0d: word %h ready %b, expected no change from %h ready %b",
              cycCnt, ctrlWord, ready, lastWord, lastRdy));
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(cycCnt == it.cyc && ctrlWord === it.word && ready === it.rdy, it.tag,
              $sformatf("actual cycle %0d word %h ready %b, expected cycle %0d word %h ready %b",
                        cycCnt, ctrlWord, ready, it.cyc, it.word, it.rdy));
      end
      lastWord = ctrlWord;
      lastRdy  = ready;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R7", "actual: run hung, expected: sequence completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ctrlWord === 32'd0 && ready === 1'b0, "R1",
          $sformatf("actual word %h ready %b, expected 0 and 0", ctrlWord, ready));
    rst = 1'b0;

    // R2 R3 R4 bring-up with oscillator fitted
    reqStart(1'b1);
    waitIdle();
    check(ready === 1'b1 && ctrlWord === mWord, "R5",
          $sformatf("actual word %h ready %b, expected %h and 1", ctrlWord, ready, mWord));

    // R8 start while powered up is dropped
    reqStart(1'b0);
    repeat (10) @(negedge clk);
    check(ctrlWord === mWord && ready === 1'b1, "R8",
          $sformatf("actual word %h ready %b, expected %h and 1", ctrlWord, ready, mWord));

    // R6 shut-down order
    reqStop();
    waitIdle();

    // R8 stop while idle is dropped
    reqStop();
    repeat (10) @(negedge clk);
    check(ctrlWord === mWord && ready === 1'b0, "R8",
          $sformatf("actual word %h ready %b, expected %h and 0", ctrlWord, ready, mWord));

    // R3 no oscillator; R8 extra start during bring-up
    reqStart(1'b0);
    repeat (5) @(negedge clk);
    reqStart(1'b1);
    oscPresent = 1'b0;
    waitIdle();
    check(ctrlWord[B_PAD] === 1'b0, "R3",
          $sformatf("actual pad %b, expected 0", ctrlWord[B_PAD]));

    // R7 start held during shut-down
    reqStop();
    reqStart(1'b1);
    waitIdle();

    // R7 stop held during bring-up
    reqStop();
    waitIdle();
    reqStart(1'b1);
    repeat (10) @(negedge clk);
    reqStop();
    waitIdle();
    check(ctrlWord[B_TPD] === 1'b1 && ready === 1'b0, "R7",
          $sformatf("actual word %h ready %b, expected retention and 0", ctrlWord, ready));

    // R1 reset while powered up
    reqStart(1'b1);
    waitIdle();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrlWord === 32'd0 && ready === 1'b0, "R1",
          $sformatf("actual word %h ready %b, expected 0 and 0", ctrlWord, ready));
    mWord = '0; mRdy = 1'b0; busyUntil = 0; mTargetOn = 1'b0;
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R4 R9 every predicted change was seen with only the five control bits used
    check(expQ.size() == 0, "R4",
          $sformatf("actual %0d pending expected items, expected 0", expQ.size()));
    check((ctrlWord & ~32'h1900_0180) == 32'd0, "R9",
          $sformatf("actual word %h, expected only bits 7 8 24 27 28", ctrlWord));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule